// File: doc/BRIEF.md
# CAN Bit Timing Quantum Generator

This block turns a packed bit-timing configuration word into the time base of a CAN node. A prescaler divides the system clock into time quanta. A segment sequencer then walks each bit through a one-quantum sync segment, the first timing segment (propagation plus phase one) and the second phase segment. It emits a strobe at the sample point and a strobe at the bit boundary. Frame logic, bit stuffing and the transceiver lie outside the block. Only the timing that those parts consume is produced here.

The configuration word and a clock-source select byte are captured only while the controller holds the block in its configuration state (`cfg_hold` high). While held, the generator stays idle. After release it runs from the captured values. An edge detector outside the block reports recessive-to-dominant bus edges on `rx_edge`. The sequencer uses them to resynchronise: it stretches the first segment or shortens the second by the phase error, bounded by the jump width. A configuration that breaks the segment limits is reported on `cfg_bad`, and the generator stays idle.

Top module: `can_bit_timer`

## Requirements
- R1: During and after reset, `tq_tick`, `sample_pt` and `bit_end` are low, `cfg_bad` is high (the cleared configuration is invalid) and `clk_sel_q` is zero.
- R2: `cfg_word` and `clk_sel` are captured on every clock edge where `cfg_hold` is high, and on no other edge. While `cfg_hold` is high, no tick or strobe is produced. Values driven while it is low change neither the timing nor `clk_sel_q`.
- R3: Every field holds its value minus one. SJW sits in bits 5:4, TSEG2 in bits 2:0, the prescaler BRP in bits 17:8 and TSEG1 in bits 23:20. Bits 19:18, 7:6 and 3 are ignored.
- R4: `cfg_bad` is high, one cycle after capture, when TSEG1 is below 4, when TSEG2 is below 2, or when SJW exceeds TSEG2. While it is high, no tick, strobe or resynchronisation happens.
- R5: While running, `tq_tick` pulses once every BRP cycles (BRP from 1 to 1024). The first pulse comes in the BRP-th cycle after `cfg_hold` falls.
- R6: Without edges, one bit lasts 1 + TSEG1 + TSEG2 quanta. `sample_pt` pulses on the tick that ends quantum 1 + TSEG1, and `bit_end` pulses on the tick that ends the last quantum. Each `bit_end` has a `sample_pt` before it in the same bit.
- R7: An edge seen in quantum q (0-based) of TSEG1 lengthens TSEG1 by min(q + 1, SJW) quanta. This holds even when the edge coincides with the tick that would have ended TSEG1.
- R8: An edge seen in quantum q of an effective TSEG2 of length L shortens TSEG2 by min(L - 1 - q, SJW) quanta. The bit therefore never ends before the current quantum.
- R9: At most one resynchronisation is applied per bit. Edges in the sync segment, while held or while the configuration is invalid are ignored.
- R10: `clk_sel_q` carries the select byte from the last held cycle unchanged and has no effect on the timing.
- R11: `sample_pt` and `bit_end` occur only together with `tq_tick` and never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hold | input | 1 | High: capture configuration and keep the generator idle |
| cfg_word | input | 24 | Packed timing configuration, fields stored minus one |
| clk_sel | input | 8 | Clock-source select byte, passed through |
| rx_edge | input | 1 | One-cycle pulse per recessive-to-dominant bus edge |
| tq_tick | output | 1 | End of a time quantum |
| sample_pt | output | 1 | Sample-point strobe |
| bit_end | output | 1 | Bit-boundary strobe |
| cfg_bad | output | 1 | Captured configuration violates the segment limits |
| clk_sel_q | output | 8 | Captured clock-source select byte |

## Verification
The three strobes are combinational on the state registers and `rx_edge`. An edge therefore acts in the very cycle it is driven, and a strobe shows up in the same cycle as the tick that ends its quantum. `cfg_bad` and `clk_sel_q` follow one edge after a held cycle. The first tick arrives BRP running cycles after release. The bench drives inputs just after the falling edge and compares all outputs a nanosecond later against a cycle-stepped model that is updated only afterwards, so each expectation refers to the state before the coming rising edge. Directed phases cover the extreme segment lengths, the largest prescaler, edges confined to each segment, an edge on every cycle and each invalid case. Seeded random configurations with sparse edges and scrambled inputs during running cover the rest.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PHA  = 2'd1,
    SEG_PHB  = 2'd2
  } seg_e;

  localparam int PHA_MIN_TQ = 4;
  localparam int PHB_MIN_TQ = 2;

  // Segment limits on decoded (plus-one) lengths.
  function automatic logic timing_ok(input int pha_tq, input int phb_tq, input int jump_tq);
    return (pha_tq >= PHA_MIN_TQ) && (phb_tq >= PHB_MIN_TQ) && (jump_tq <= phb_tq);
  endfunction

endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg
  import can_bt_pkg::*;
#(
  parameter int CFG_W   = 24,
  parameter int BRP_W   = 10,
  parameter int PHA_W   = 4,
  parameter int PHB_W   = 3,
  parameter int JMP_W   = 2,
  parameter int SEL_W   = 8,
  parameter int PHA_LSB = 20,
  parameter int BRP_LSB = 8,
  parameter int JMP_LSB = 4,
  parameter int PHB_LSB = 0,
  parameter int LEN_W   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg_in,
  input  logic [SEL_W-1:0] sel_in,
  output logic [BRP_W-1:0] brp_last,
  output logic [LEN_W-1:0] pha_len,
  output logic [LEN_W-1:0] phb_len,
  output logic [LEN_W-1:0] jmp_len,
  output logic             cfg_ok,
  output logic [SEL_W-1:0] sel_q
);

  logic [PHA_W-1:0] pha_f;
  logic [PHB_W-1:0] phb_f;
  logic [JMP_W-1:0] jmp_f;
  logic [BRP_W-1:0] brp_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pha_f <= '0;
      phb_f <= '0;
      jmp_f <= '0;
      brp_f <= '0;
      sel_q <= '0;
    end else if (load) begin
      pha_f <= cfg_in[PHA_LSB +: PHA_W];
      phb_f <= cfg_in[PHB_LSB +: PHB_W];
      jmp_f <= cfg_in[JMP_LSB +: JMP_W];
      brp_f <= cfg_in[BRP_LSB +: BRP_W];
      sel_q <= sel_in;
    end
  end

  assign brp_last = brp_f;
  assign pha_len  = LEN_W'(pha_f) + LEN_W'(1);
  assign phb_len  = LEN_W'(phb_f) + LEN_W'(1);
  assign jmp_len  = LEN_W'(jmp_f) + LEN_W'(1);
  assign cfg_ok   = timing_ok(int'(pha_len), int'(phb_len), int'(jmp_len));

endmodule

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
  parameter int BRP_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [BRP_W-1:0] brp_last,
  output logic             tick
);

  logic [BRP_W-1:0] pcnt;

  assign tick = run && (pcnt == brp_last);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      pcnt <= '0;
    end else if (tick) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + BRP_W'(1);
    end
  end

endmodule

// File: rtl/can_bt_seg.sv
module can_bt_seg
  import can_bt_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             rx_edge,
  input  logic [LEN_W-1:0] pha_len,
  input  logic [LEN_W-1:0] phb_len,
  input  logic [LEN_W-1:0] jmp_len,
  output logic             sample_pt,
  output logic             bit_end,
  output logic             resync_ev
);

  seg_e             seg;
  logic [LEN_W-1:0] qcnt;
  logic [LEN_W-1:0] cur_len;
  logic             resynced;
  logic [LEN_W-1:0] len_now;
  logic             seg_done;

  function automatic logic [LEN_W-1:0] lmin(input logic [LEN_W-1:0] a, input logic [LEN_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // Late edge in phase A: phase error is the quanta elapsed in it, including this one.
  function automatic logic [LEN_W-1:0] stretch_by(input logic [LEN_W-1:0] pos, input logic [LEN_W-1:0] jmp);
    return lmin(pos + LEN_W'(1), jmp);
  endfunction

  // Early edge in phase B: phase error is the quanta still left after this one.
  function automatic logic [LEN_W-1:0] shrink_by(input logic [LEN_W-1:0] len, input logic [LEN_W-1:0] pos,
                                                 input logic [LEN_W-1:0] jmp);
    return lmin(len - LEN_W'(1) - pos, jmp);
  endfunction

  assign resync_ev = run && rx_edge && !resynced && (seg != SEG_SYNC);

  always_comb begin
    len_now = cur_len;
    if (resync_ev && seg == SEG_PHA) len_now = cur_len + stretch_by(qcnt, jmp_len);
    if (resync_ev && seg == SEG_PHB) len_now = cur_len - shrink_by(cur_len, qcnt, jmp_len);
  end

  assign seg_done  = tick && (qcnt == len_now - LEN_W'(1));
  assign sample_pt = seg_done && (seg == SEG_PHA);
  assign bit_end   = seg_done && (seg == SEG_PHB);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      seg      <= SEG_SYNC;
      qcnt     <= '0;
      cur_len  <= LEN_W'(1);
      resynced <= 1'b0;
    end else begin
      if (resync_ev) resynced <= 1'b1;
      if (seg_done) begin
        qcnt <= '0;
        unique case (seg)
          SEG_SYNC: begin
            seg     <= SEG_PHA;
            cur_len <= pha_len;
          end
          SEG_PHA: begin
            seg     <= SEG_PHB;
            cur_len <= phb_len;
          end
          default: begin
            seg      <= SEG_SYNC;
            cur_len  <= LEN_W'(1);
            resynced <= 1'b0;
          end
        endcase
      end else begin
        if (tick) qcnt <= qcnt + LEN_W'(1);
        cur_len <= len_now;
      end
    end
  end

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int CFG_W   = 24,
  parameter int BRP_W   = 10,
  parameter int PHA_W   = 4,
  parameter int PHB_W   = 3,
  parameter int JMP_W   = 2,
  parameter int SEL_W   = 8,
  parameter int PHA_LSB = 20,
  parameter int BRP_LSB = 8,
  parameter int JMP_LSB = 4,
  parameter int PHB_LSB = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_hold,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             rx_edge,
  output logic             tq_tick,
  output logic             sample_pt,
  output logic             bit_end,
  output logic             cfg_bad,
  output logic [SEL_W-1:0] clk_sel_q
);

  localparam int SEG_MAX_W = (PHA_W > PHB_W) ? PHA_W : PHB_W;
  localparam int LEN_W     = SEG_MAX_W + 2;

  logic [BRP_W-1:0] brp_last;
  logic [LEN_W-1:0] pha_len;
  logic [LEN_W-1:0] phb_len;
  logic [LEN_W-1:0] jmp_len;
  logic             cfg_ok;
  logic             run;
  logic             resync_ev;

  can_bt_cfg #(
    .CFG_W(CFG_W), .BRP_W(BRP_W), .PHA_W(PHA_W), .PHB_W(PHB_W), .JMP_W(JMP_W),
    .SEL_W(SEL_W), .PHA_LSB(PHA_LSB), .BRP_LSB(BRP_LSB), .JMP_LSB(JMP_LSB),
    .PHB_LSB(PHB_LSB), .LEN_W(LEN_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_hold), .cfg_in(cfg_word), .sel_in(clk_sel),
    .brp_last(brp_last), .pha_len(pha_len), .phb_len(phb_len), .jmp_len(jmp_len),
    .cfg_ok(cfg_ok), .sel_q(clk_sel_q)
  );

  assign run     = !cfg_hold && cfg_ok;
  assign cfg_bad = !cfg_ok;

  can_bt_presc #(.BRP_W(BRP_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .brp_last(brp_last), .tick(tq_tick)
  );

  can_bt_seg #(.LEN_W(LEN_W)) u_seg (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tq_tick), .rx_edge(rx_edge),
    .pha_len(pha_len), .phb_len(phb_len), .jmp_len(jmp_len),
    .sample_pt(sample_pt), .bit_end(bit_end), .resync_ev(resync_ev)
  );

endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk #(
  parameter int SEL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_hold,
  input logic             cfg_bad,
  input logic             tq_tick,
  input logic             sample_pt,
  input logic             bit_end,
  input logic [SEL_W-1:0] clk_sel_q,
  input logic             resync_ev
);

  logic idle;
  logic saw_sample;
  logic saw_resync;

  assign idle = cfg_hold || cfg_bad;

  always_ff @(posedge clk) begin
    if (!rst_n || idle || bit_end) begin
      saw_sample <= 1'b0;
      saw_resync <= 1'b0;
    end else begin
      if (sample_pt) saw_sample <= 1'b1;
      if (resync_ev) saw_resync <= 1'b1;
    end
  end

  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) (sample_pt || bit_end) |-> tq_tick); // R11
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) !(sample_pt && bit_end)); // R11
  AST_HELD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cfg_hold |-> !tq_tick); // R2
  AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) cfg_bad |-> !(tq_tick || sample_pt || bit_end)); // R4
  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) !cfg_hold |=> $stable(clk_sel_q)); // R10
  AST_SAMPLE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) bit_end |-> saw_sample); // R6
  AST_ONE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n) resync_ev |-> !saw_resync); // R9
  AST_IDLE_NO_RESYNC: assert property (@(posedge clk) disable iff (!rst_n) idle |-> !resync_ev); // R9

endmodule

bind can_bit_timer can_bit_timer_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_bad(cfg_bad), .tq_tick(tq_tick),
  .sample_pt(sample_pt), .bit_end(bit_end), .clk_sel_q(clk_sel_q), .resync_ev(resync_ev)
);

// File: tb/tb_can_bit_timer.sv
module tb_can_bit_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_hold = 1'b0;
  logic [23:0] cfg_word = '0;
  logic [7:0]  clk_sel = '0;
  logic        rx_edge = 1'b0;
  logic        tq_tick, sample_pt, bit_end, cfg_bad;
  logic [7:0]  clk_sel_q;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string ptag = "R6";

  // model state
  logic [23:0] m_cfg = '0;
  logic [7:0]  m_csel = '0;
  int m_pc = 0, m_qpos = 0, m_ext = 0, m_shr = 0;
  bit m_sync = 0;

  always #2.5 clk = ~clk;

  can_bit_timer dut (
    .clk(clk), .rst_n(rst_n), .cfg_hold(cfg_hold), .cfg_word(cfg_word), .clk_sel(clk_sel),
    .rx_edge(rx_edge), .tq_tick(tq_tick), .sample_pt(sample_pt), .bit_end(bit_end),
    .cfg_bad(cfg_bad), .clk_sel_q(clk_sel_q)
  );

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  function automatic int f_a(input logic [23:0] w); return int'(w[23:20]) + 1; endfunction
  function automatic int f_b(input logic [23:0] w); return int'(w[2:0]) + 1; endfunction
  function automatic int f_j(input logic [23:0] w); return int'(w[5:4]) + 1; endfunction
  function automatic int f_p(input logic [23:0] w); return int'(w[17:8]) + 1; endfunction

  function automatic logic [23:0] mk(input int a, input int p, input int j, input int b);
    return 24'(((a - 1) << 20) | ((p - 1) << 8) | ((j - 1) << 4) | (b - 1));
  endfunction

  // 0 sync, 1 first segment, 2 second segment
  function automatic int m_segk();
    if (m_qpos == 0) return 0;
    if (m_qpos < 1 + f_a(m_cfg) + m_ext) return 1;
    return 2;
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s t=%0t actual=%0d expected=%0d", tag, what, $time, got, exp);
    end
  endtask

  task automatic step(input bit h, input logic [23:0] w, input logic [7:0] cs, input bit e);
    int a, b, j, p, q, segk;
    bit ok, run, tk, es, ee;
    @(negedge clk);
    cfg_hold = h; cfg_word = w; clk_sel = cs; rx_edge = e;
    #1;
    a = f_a(m_cfg); b = f_b(m_cfg); j = f_j(m_cfg); p = f_p(m_cfg);
    ok = (a >= 4) && (b >= 2) && (j <= b);
    run = !h && ok;
    tk = 0; es = 0; ee = 0;
    if (run) begin
      tk = (m_pc == p - 1);
      segk = m_segk();
      if (e && !m_sync && segk == 1) begin
        q = m_qpos - 1;
        m_ext = imin(q + 1, j);
        m_sync = 1;
      end else if (e && !m_sync && segk == 2) begin
        q = m_qpos - 1 - a - m_ext;
        m_shr = imin(b - 1 - q, j);
        m_sync = 1;
      end
      es = tk && segk == 1 && m_qpos == a + m_ext;
      ee = tk && segk == 2 && m_qpos == a + m_ext + b - m_shr;
    end
    chk("R4", "cfg_bad", int'(cfg_bad), int'(!ok));
    chk("R5", "tq_tick", int'(tq_tick), int'(tk));
    chk(ptag, "sample_pt", int'(sample_pt), int'(es));
    chk(ptag, "bit_end", int'(bit_end), int'(ee));
    chk("R11", "dual_strobe", int'(sample_pt && bit_end), 0);
    chk("R10", "clk_sel_q", int'(clk_sel_q), int'(m_csel));
    if (run) begin
      m_pc = tk ? 0 : m_pc + 1;
      if (tk) begin
        if (ee) begin
          m_qpos = 0; m_ext = 0; m_shr = 0; m_sync = 0;
        end else m_qpos++;
      end
    end else begin
      m_pc = 0; m_qpos = 0; m_ext = 0; m_shr = 0; m_sync = 0;
    end
    if (h) begin
      m_cfg = w; m_csel = cs;
    end
  endtask

  // mode: 0 none, 1 sparse random, 2 every cycle, 3 first segment only, 4 second segment only
  task automatic run_phase(input logic [23:0] w, input int n, input int mode, input string tag);
    logic [7:0] cs;
    bit e;
    ptag = tag;
    cs = 8'($urandom);
    for (int k = 0; k < 3; k++) step(1'b1, w, cs, 1'b0);
    for (int i = 0; i < n; i++) begin
      case (mode)
        1: e = ($urandom % 12) == 0;
        2: e = 1'b1;
        3: e = (m_segk() == 1) && (($urandom % 3) == 0);
        4: e = (m_segk() == 2) && (($urandom % 3) == 0);
        default: e = 1'b0;
      endcase
      // R2: scrambled configuration and select while running must be ignored
      step(1'b0, 24'($urandom), 8'($urandom), e);
    end
  endtask

  function automatic logic [23:0] rnd_cfg();
    int a, b, j, p;
    logic [23:0] junk;
    a = 4 + int'($urandom % 13);
    b = 2 + int'($urandom % 7);
    j = 1 + int'($urandom % imin(4, b));
    p = 1 + int'($urandom % 4);
    junk = 24'($urandom) & 24'h0C00C8; // R3: ignored bits
    return mk(a, p, j, b) | junk;
  endfunction

  initial begin
    void'($urandom(32'd77));
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk("R1", "tq_tick", int'(tq_tick), 0);
    chk("R1", "sample_pt", int'(sample_pt), 0);
    chk("R1", "bit_end", int'(bit_end), 0);
    chk("R1", "cfg_bad", int'(cfg_bad), 1);
    chk("R1", "clk_sel_q", int'(clk_sel_q), 0);
    rst_n = 1'b1;
    ptag = "R1";
    for (int i = 0; i < 8; i++) step(1'b0, 24'($urandom), 8'($urandom), 1'b1);

    run_phase(mk(5, 3, 2, 3), 120, 0, "R3");
    run_phase(mk(16, 1, 4, 8), 200, 0, "R6");
    run_phase(mk(4, 1, 1, 2), 60, 0, "R6");
    run_phase(mk(4, 1024, 1, 2), 2100, 0, "R5");
    run_phase(mk(8, 2, 3, 4), 400, 3, "R7");
    run_phase(mk(16, 1, 4, 8), 400, 3, "R7");
    run_phase(mk(8, 2, 3, 4), 400, 4, "R8");
    run_phase(mk(6, 1, 4, 4), 400, 4, "R8");
    run_phase(mk(7, 1, 2, 3), 300, 2, "R9");
    run_phase(mk(3, 1, 1, 2), 40, 1, "R4");
    run_phase(mk(8, 1, 1, 1), 40, 1, "R4");
    run_phase(mk(8, 1, 3, 2), 40, 1, "R4");
    run_phase(mk(9, 2, 2, 5), 300, 1, "R2");
    for (int r = 0; r < 30; r++) run_phase(rnd_cfg(), 300, 1, "R6");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule